// File: doc/BRIEF.md
# Interrupt Status Combiner

This block merges the condition flags of a serial bus controller into one registered interrupt line. Three flags (bus error, negative acknowledge, data-ready) request service on their own. Four others (address not-matched, end-of-busy, receive threshold, receive-full/transmit-empty) count only when their own enable bit is set. The transmit-threshold flag also needs its enable, and this block holds that flag. Everything sits behind a global enable. While the global enable is clear, the line freezes at its last value. The registered level is mirrored into bit 7 of a read-only interrupt-status byte.

The block also owns the few status and control bytes whose write rules feed or guard the interrupt:
- a control-status byte whose bus-busy bit is cleared by writing 1;
- the transmit-threshold flag, also cleared by writing 1;
- a timeout byte whose status bit 7 survives a write only while it is set and the write carries 0 there;
- a third control byte whose two bus-level bits cannot be written.

The transaction engine drives the flag inputs and the set events. The register access logic drives the write strobes and the write data.

Top module: `irq_status_combiner`

## Requirements
- R1: After reset `irq_o` is 0, `cs2_rd_o` is 0x00, `cs_rd_o` is 0x10, `txs_rd_o` is 0x00, `tmo_rd_o` is 0x3F and `ctl3_rd_o` is 0xC0.
- R2: With `gie_i` high, `irq_o` is 1 in the cycle after any of `berr_i`, `nak_i`, `drdy_i` is high. These three need no individual enable.
- R3: `nmatch_i` contributes only together with `nm_ie_i`, and `eob_i` only together with `eob_ie_i`.
- R4: `rx_thr_i` contributes only with `rx_thr_ie_i`, the held transmit-threshold flag only with `tx_thr_ie_i`, and `fifo_flag_i` only with `fifo_ie_i`. When all enabled contributions are 0 and `gie_i` is high, `irq_o` is 0 one cycle later.
- R5: While `gie_i` is low, `irq_o` and the mirror bit keep their previous values, whatever the flags do.
- R6: Bit 7 of `cs2_rd_o` always equals `irq_o`, and bits 6..0 of `cs2_rd_o` read 0.
- R7: Bit 1 of `cs_rd_o` (bus busy) is set by `busy_set_i`, or by `cs_load_i` with data bit 1 high. It is cleared by `wr_cs_i` with `wr_data_i[1]`=1, and a set wins over a clear in the same cycle. `cs_load_i` loads all other bits from `cs_load_data_i`. `wr_cs_i` changes no bit but bit 1.
- R8: The transmit-threshold flag is read at bit 6 of `txs_rd_o`, with all other bits 0. It is set by `txthr_set_i`. It is cleared by `wr_txs_i` with `wr_data_i[6]`=1, and is unchanged when that bit is 0. A set wins over a clear.
- R9: `wr_tmo_i` writes bits 6..0 of the timeout byte. The new bit 7 is 1 only when the old bit 7 was 1 and `wr_data_i[7]` is 0. `tmo_set_i` sets bit 7 and wins over a write.
- R10: `wr_ctl3_i` writes bits 5..0 of `ctl3_rd_o`. Bits 7 and 6 keep their value (1 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie_i | input | 1 | Global interrupt enable |
| nm_ie_i | input | 1 | Enable for address not-matched |
| eob_ie_i | input | 1 | Enable for end-of-busy |
| rx_thr_ie_i | input | 1 | Enable for receive threshold |
| tx_thr_ie_i | input | 1 | Enable for transmit threshold |
| fifo_ie_i | input | 1 | Enable for receive-full/transmit-empty |
| berr_i | input | 1 | Bus error flag |
| nak_i | input | 1 | Negative acknowledge flag |
| drdy_i | input | 1 | Data-ready flag |
| nmatch_i | input | 1 | Address not-matched flag |
| eob_i | input | 1 | End-of-busy flag |
| rx_thr_i | input | 1 | Receive threshold flag |
| fifo_flag_i | input | 1 | Receive-full/transmit-empty flag |
| busy_set_i | input | 1 | Sets bus busy |
| txthr_set_i | input | 1 | Sets transmit-threshold flag |
| tmo_set_i | input | 1 | Sets timeout status bit |
| cs_load_i | input | 1 | Engine load of the control-status byte |
| cs_load_data_i | input | 8 | Data for the engine load |
| wr_data_i | input | 8 | Register write data |
| wr_cs_i | input | 1 | Write strobe, control-status byte |
| wr_txs_i | input | 1 | Write strobe, transmit status byte |
| wr_tmo_i | input | 1 | Write strobe, timeout byte |
| wr_ctl3_i | input | 1 | Write strobe, third control byte |
| irq_o | output | 1 | Registered interrupt line |
| cs_rd_o | output | 8 | Control-status byte |
| cs2_rd_o | output | 8 | Interrupt-status byte, mirror at bit 7 |
| txs_rd_o | output | 8 | Transmit status byte |
| tmo_rd_o | output | 8 | Timeout byte |
| ctl3_rd_o | output | 8 | Third control byte |

## Verification
The bench checks each gated flag with its enable clear and then set. A design that let a gated flag through without its enable would raise a spurious interrupt. The bench drops the global enable while flags change, and a design that keeps tracking them instead of freezing the line fails there. Writes of 0 to the clear-on-one bits, a set arriving in the same cycle as a clear, and a 0 written over a set timeout bit catch designs that clear on any write, lose the set, or treat the timeout bit as plain read-write. A write of all zeros to the third control byte catches a design that lets the bus-level bits be overwritten.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int DW = 8;

  // bit positions of the bytes this block presents
  localparam int CS_BUSY  = 1;
  localparam int TXS_THR  = 6;
  localparam int TMO_ST   = 7;
  localparam int CS2_INT  = 7;
  localparam int CTL3_LVL = 6;  // bits CTL3_LVL+1 .. CTL3_LVL are levels

  localparam logic [DW-1:0] CS_RST   = 8'h10;
  localparam logic [DW-1:0] TMO_RST  = 8'h3F;
  localparam logic [DW-1:0] CTL3_RST = 8'hC0;

  // number of clear-on-one flags held here
  localparam int NFLAG    = 2;
  localparam int F_BUSY   = 0;
  localparam int F_TXTHR  = 1;

  typedef struct packed {
    logic berr;
    logic nak;
    logic drdy;
    logic nmatch;
    logic eob;
    logic rxthr;
    logic txthr;
    logic fifo;
  } irq_src_t;
endpackage

// File: rtl/irqc_w1c_flag.sv
`timescale 1ns/1ps
module irqc_w1c_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic q, d, en;

  assign en = set_i | clr_i;

  always_comb begin
    d = q;
    if (clr_i) d = 1'b0;
    if (set_i) d = 1'b1;   // set has priority
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (en) q <= d;
  end

  assign flag_o = q;
endmodule

// File: rtl/irqc_merge.sv
`timescale 1ns/1ps
module irqc_merge
  import irqc_pkg::*;
(
  input  irq_src_t src_i,
  input  irq_src_t mask_i,
  output logic     level_o
);
  assign level_o = |(src_i & mask_i);
endmodule

// File: rtl/irqc_ctrl_regs.sv
`timescale 1ns/1ps
module irqc_ctrl_regs
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_set_i,
  input  logic          txthr_set_i,
  input  logic          tmo_set_i,
  input  logic          cs_load_i,
  input  logic [DW-1:0] cs_load_data_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_cs_i,
  input  logic          wr_txs_i,
  input  logic          wr_tmo_i,
  input  logic          wr_ctl3_i,
  output logic [DW-1:0] cs_rd_o,
  output logic          txthr_o,
  output logic [DW-1:0] tmo_rd_o,
  output logic [DW-1:0] ctl3_rd_o
);
  localparam int LVL_W = 2;

  logic [NFLAG-1:0] set_v, clr_v, flag_v;

  assign set_v[F_BUSY]  = busy_set_i | (cs_load_i & cs_load_data_i[CS_BUSY]);
  assign clr_v[F_BUSY]  = wr_cs_i & wr_data_i[CS_BUSY];
  assign set_v[F_TXTHR] = txthr_set_i;
  assign clr_v[F_TXTHR] = wr_txs_i & wr_data_i[TXS_THR];

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    irqc_w1c_flag #(.RST_VAL(1'b0)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .flag_o (flag_v[g])
    );
  end

  // control-status byte without the busy bit
  logic [DW-2:0] cs_q, cs_d;
  assign cs_d = {cs_load_data_i[DW-1:CS_BUSY+1], cs_load_data_i[CS_BUSY-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cs_q <= {CS_RST[DW-1:CS_BUSY+1], CS_RST[CS_BUSY-1:0]};
    else if (cs_load_i) cs_q <= cs_d;
  end

  assign cs_rd_o = {cs_q[DW-2:CS_BUSY], flag_v[F_BUSY], cs_q[CS_BUSY-1:0]};
  assign txthr_o = flag_v[F_TXTHR];

  // timeout byte
  logic [DW-1:0] tmo_q, tmo_d;
  logic          tmo_en;
  assign tmo_en = wr_tmo_i | tmo_set_i;

  always_comb begin
    tmo_d = tmo_q;
    if (wr_tmo_i) begin
      tmo_d[TMO_ST-1:0] = wr_data_i[TMO_ST-1:0];
      tmo_d[TMO_ST]     = tmo_q[TMO_ST] & ~wr_data_i[TMO_ST];
    end
    if (tmo_set_i) tmo_d[TMO_ST] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_q <= TMO_RST;
    else if (tmo_en) tmo_q <= tmo_d;
  end

  assign tmo_rd_o = tmo_q;

  // third control byte: level bits not writable
  logic [DW-1:0] ctl3_q, ctl3_d;
  assign ctl3_d = {ctl3_q[CTL3_LVL+LVL_W-1:CTL3_LVL], wr_data_i[CTL3_LVL-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctl3_q <= CTL3_RST;
    else if (wr_ctl3_i) ctl3_q <= ctl3_d;
  end

  assign ctl3_rd_o = ctl3_q;

  // R7: busy set and clear
  p_busy_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_set_i |=> cs_rd_o[CS_BUSY]);
  p_busy_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cs_i && wr_data_i[CS_BUSY] && !busy_set_i &&
     !(cs_load_i && cs_load_data_i[CS_BUSY])) |=> !cs_rd_o[CS_BUSY]);
  // R8: threshold flag clear and hold
  p_txthr_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txs_i && wr_data_i[TXS_THR] && !txthr_set_i) |=> !txthr_o);
  p_txthr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (txthr_o && !(wr_txs_i && wr_data_i[TXS_THR])) |=> txthr_o);
  // R9: timeout bit rules
  p_tmo_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tmo_i && !wr_data_i[TMO_ST] && tmo_q[TMO_ST]) |=> tmo_q[TMO_ST]);
  p_tmo_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tmo_i && wr_data_i[TMO_ST] && !tmo_set_i) |=> !tmo_q[TMO_ST]);
  // R10: level bits never written
  p_ctl3_lvl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl3_i |=> $stable(ctl3_q[DW-1:CTL3_LVL]));
endmodule

// File: rtl/irq_status_combiner.sv
`timescale 1ns/1ps
module irq_status_combiner
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gie_i,
  input  logic          nm_ie_i,
  input  logic          eob_ie_i,
  input  logic          rx_thr_ie_i,
  input  logic          tx_thr_ie_i,
  input  logic          fifo_ie_i,
  input  logic          berr_i,
  input  logic          nak_i,
  input  logic          drdy_i,
  input  logic          nmatch_i,
  input  logic          eob_i,
  input  logic          rx_thr_i,
  input  logic          fifo_flag_i,
  input  logic          busy_set_i,
  input  logic          txthr_set_i,
  input  logic          tmo_set_i,
  input  logic          cs_load_i,
  input  logic [DW-1:0] cs_load_data_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_cs_i,
  input  logic          wr_txs_i,
  input  logic          wr_tmo_i,
  input  logic          wr_ctl3_i,
  output logic          irq_o,
  output logic [DW-1:0] cs_rd_o,
  output logic [DW-1:0] cs2_rd_o,
  output logic [DW-1:0] txs_rd_o,
  output logic [DW-1:0] tmo_rd_o,
  output logic [DW-1:0] ctl3_rd_o
);
  logic     txthr;
  logic     level;
  irq_src_t src, mask;

  irqc_ctrl_regs u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy_set_i     (busy_set_i),
    .txthr_set_i    (txthr_set_i),
    .tmo_set_i      (tmo_set_i),
    .cs_load_i      (cs_load_i),
    .cs_load_data_i (cs_load_data_i),
    .wr_data_i      (wr_data_i),
    .wr_cs_i        (wr_cs_i),
    .wr_txs_i       (wr_txs_i),
    .wr_tmo_i       (wr_tmo_i),
    .wr_ctl3_i      (wr_ctl3_i),
    .cs_rd_o        (cs_rd_o),
    .txthr_o        (txthr),
    .tmo_rd_o       (tmo_rd_o),
    .ctl3_rd_o      (ctl3_rd_o)
  );

  always_comb begin
    src.berr    = berr_i;
    src.nak     = nak_i;
    src.drdy    = drdy_i;
    src.nmatch  = nmatch_i;
    src.eob     = eob_i;
    src.rxthr   = rx_thr_i;
    src.txthr   = txthr;
    src.fifo    = fifo_flag_i;
    mask.berr   = 1'b1;
    mask.nak    = 1'b1;
    mask.drdy   = 1'b1;
    mask.nmatch = nm_ie_i;
    mask.eob    = eob_ie_i;
    mask.rxthr  = rx_thr_ie_i;
    mask.txthr  = tx_thr_ie_i;
    mask.fifo   = fifo_ie_i;
  end

  irqc_merge u_merge (
    .src_i   (src),
    .mask_i  (mask),
    .level_o (level)
  );

  // registered line, updated only under the global enable
  logic irq_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (gie_i) irq_q <= level;
  end

  assign irq_o    = irq_q;
  assign cs2_rd_o = {irq_q, {(DW-1){1'b0}}};
  assign txs_rd_o = {{(DW-1-TXS_THR){1'b0}}, txthr, {TXS_THR{1'b0}}};

  // R2: ungated flags raise the line
  p_ungated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_i && (berr_i || nak_i || drdy_i)) |=> irq_o);
  // R3: gated not-matched source
  p_nmatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_i && nmatch_i && nm_ie_i) |=> irq_o);
  // R4: gated fifo source
  p_fifo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_i && fifo_flag_i && fifo_ie_i) |=> irq_o);
  // R5: frozen without global enable
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> $stable(irq_o));
  // R4: nothing asserted, line drops
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_i && !berr_i && !nak_i && !drdy_i && !(nmatch_i && nm_ie_i) &&
     !(eob_i && eob_ie_i) && !(rx_thr_i && rx_thr_ie_i) &&
     !(txthr && tx_thr_ie_i) && !(fifo_flag_i && fifo_ie_i)) |=> !irq_o);
endmodule

// File: tb/test_irq_status_combiner.sv
`timescale 1ns/1ps
module test_irq_status_combiner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gie = 0, nm_ie = 0, eob_ie = 0, rx_ie = 0, tx_ie = 0, f_ie = 0;
  logic       berr = 0, nak = 0, drdy = 0, nm = 0, eob = 0, rx = 0, ff = 0;
  logic       busy_set = 0, txthr_set = 0, tmo_set = 0, cs_load = 0;
  logic [7:0] cs_load_data = 0, wr_data = 0;
  logic       wr_cs = 0, wr_txs = 0, wr_tmo = 0, wr_ctl3 = 0;
  logic       irq;
  logic [7:0] cs_rd, cs2_rd, txs_rd, tmo_rd, ctl3_rd;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  irq_status_combiner i_irq_status_combiner (
    .clk(clk), .rst_n(rst_n), .gie_i(gie), .nm_ie_i(nm_ie), .eob_ie_i(eob_ie),
    .rx_thr_ie_i(rx_ie), .tx_thr_ie_i(tx_ie), .fifo_ie_i(f_ie),
    .berr_i(berr), .nak_i(nak), .drdy_i(drdy), .nmatch_i(nm), .eob_i(eob),
    .rx_thr_i(rx), .fifo_flag_i(ff), .busy_set_i(busy_set),
    .txthr_set_i(txthr_set), .tmo_set_i(tmo_set), .cs_load_i(cs_load),
    .cs_load_data_i(cs_load_data), .wr_data_i(wr_data), .wr_cs_i(wr_cs),
    .wr_txs_i(wr_txs), .wr_tmo_i(wr_tmo), .wr_ctl3_i(wr_ctl3),
    .irq_o(irq), .cs_rd_o(cs_rd), .cs2_rd_o(cs2_rd), .txs_rd_o(txs_rd),
    .tmo_rd_o(tmo_rd), .ctl3_rd_o(ctl3_rd)
  );

  // {gie, nm_ie, eob_ie, rx_ie, tx_ie, f_ie, berr, nak, drdy, nm, eob, rx, ff, expected irq}
  localparam int NV = 18;
  localparam logic [13:0] VEC [NV] = '{
    14'b1_00000_1000000_1,  // berr alone
    14'b1_00000_0000000_0,  // quiet
    14'b1_00000_0100000_1,  // nak alone
    14'b1_00000_0010000_1,  // drdy alone
    14'b1_00000_0001000_0,  // not-matched, no enable
    14'b1_10000_0001000_1,  // not-matched, enabled
    14'b1_00000_0000100_0,  // end-of-busy, no enable
    14'b1_01000_0000100_1,  // end-of-busy, enabled
    14'b1_00000_0000010_0,  // rx threshold, no enable
    14'b1_00100_0000010_1,  // rx threshold, enabled
    14'b1_00000_0000001_0,  // fifo flag, no enable
    14'b1_00001_0000001_1,  // fifo flag, enabled
    14'b1_00001_0000000_0,  // enable without flag
    14'b0_00000_1000000_0,  // frozen low
    14'b1_00000_1000000_1,  // rise
    14'b0_00000_0000000_1,  // frozen high
    14'b0_00000_0100000_1,  // frozen high
    14'b1_00000_0000000_0   // release, drops
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int which, input logic [7:0] d);
    wr_data = d;
    case (which)
      0: wr_cs   = 1'b1;
      1: wr_txs  = 1'b1;
      2: wr_tmo  = 1'b1;
      default: wr_ctl3 = 1'b1;
    endcase
    tick();
    wr_cs = 0; wr_txs = 0; wr_tmo = 0; wr_ctl3 = 0; wr_data = 8'h00;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 cs2", cs2_rd, 8'h00);
    chk("R1 cs", cs_rd, 8'h10);
    chk("R1 txs", txs_rd, 8'h00);
    chk("R1 tmo", tmo_rd, 8'h3F);
    chk("R1 ctl3", ctl3_rd, 8'hC0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R4 R5 R6: vector walk
    for (int i = 0; i < NV; i++) begin
      {gie, nm_ie, eob_ie, rx_ie, tx_ie, f_ie, berr, nak, drdy, nm, eob, rx, ff} = VEC[i][13:1];
      tick();
      chk("R2/R3/R4/R5 irq", {7'b0, irq}, {7'b0, VEC[i][0]});
      chk("R6 mirror", cs2_rd, {VEC[i][0], 7'b0});
    end

    // R8 R4: transmit threshold flag
    gie = 1; tx_ie = 1;
    txthr_set = 1; tick(); txthr_set = 0;
    chk("R8 set", txs_rd, 8'h40);
    chk("R4 tx not yet", {7'b0, irq}, 8'h00);
    tick();
    chk("R4 tx enabled", {7'b0, irq}, 8'h01);
    wr(1, 8'h00);
    chk("R8 write0 kept", txs_rd, 8'h40);
    wr(1, 8'h40);
    chk("R8 cleared", txs_rd, 8'h00);
    tick();
    chk("R4 tx drop", {7'b0, irq}, 8'h00);
    tx_ie = 0;
    txthr_set = 1; tick(); txthr_set = 0; tick();
    chk("R4 tx gated", {7'b0, irq}, 8'h00);
    txthr_set = 1; wr(1, 8'h40); txthr_set = 0;
    chk("R8 set wins", txs_rd, 8'h40);
    wr(1, 8'hFF);
    chk("R8 clear", txs_rd, 8'h00);

    // R7: bus busy
    busy_set = 1; tick(); busy_set = 0;
    chk("R7 set", cs_rd, 8'h12);
    wr(0, 8'hFD);
    chk("R7 other bits ignored", cs_rd, 8'h12);
    wr(0, 8'h02);
    chk("R7 w1c", cs_rd, 8'h10);
    busy_set = 1; wr(0, 8'h02); busy_set = 0;
    chk("R7 set wins", cs_rd, 8'h12);
    wr(0, 8'h02);
    cs_load = 1; cs_load_data = 8'hEB; tick(); cs_load = 0;
    chk("R7 load", cs_rd, 8'hEB);
    wr(0, 8'h02);
    chk("R7 load then clear", cs_rd, 8'hE9);

    // R9: timeout byte
    wr(2, 8'h15);
    chk("R9 write", tmo_rd, 8'h15);
    tmo_set = 1; tick(); tmo_set = 0;
    chk("R9 set", tmo_rd, 8'h95);
    wr(2, 8'h00);
    chk("R9 keep", tmo_rd, 8'h80);
    wr(2, 8'h80);
    chk("R9 clear", tmo_rd, 8'h00);
    wr(2, 8'h80);
    chk("R9 stays clear", tmo_rd, 8'h00);
    tmo_set = 1; wr(2, 8'hAA); tmo_set = 0;
    chk("R9 set wins", tmo_rd, 8'hAA);

    // R10: third control byte
    wr(3, 8'h00);
    chk("R10 levels kept", ctl3_rd, 8'hC0);
    wr(3, 8'h25);
    chk("R10 low bits", ctl3_rd, 8'hE5);

    done = 1;
    finish_run();
  end
endmodule